// File: doc/BRIEF.md
# Postfix Stack Evaluator

This block is a small stack machine that evaluates integer expressions written in postfix order. Instructions arrive one per cycle over a valid/ready handshake. Each instruction either pushes a sign-extended byte onto the stack or applies one of four binary operations to the two uppermost entries. The block always shows the current top of stack and the number of entries held. A caller feeds it the postfix form of an expression and reads the result from the top once the last instruction has been accepted.

Add, subtract and multiply finish in the cycle that accepts them. Divide runs on an iterative restoring divider. While that divider works, the block stalls the instruction stream. Illegal requests leave the stack exactly as it was and raise a sticky error flag.

Top module: `postfix_stack_eval`

## Requirements
- R1: After reset, depth is 0, top_value is 0, err is 0 and in_ready is 1. Whenever depth is 0, top_value reads 0.
- R2: Opcode 3'b000 (push) accepted with fewer than 16 entries stores in_imm, sign-extended to 32 bits, as the new top and raises depth by one.
- R3: Opcodes 3'b001 (add), 3'b010 (subtract) and 3'b011 (multiply), when accepted with at least two entries, replace the two uppermost entries with one result in a single cycle. The deeper entry is the left operand. Results wrap modulo 2^32.
- R4: Opcode 3'b100 (divide) with at least two entries and a nonzero top replaces the two entries with the quotient of the deeper entry divided by the top, truncated toward zero. The quotient appears after 32 cycles, and in_ready is low for exactly those 32 cycles. The case -2^31 / -1 wraps to -2^31.
- R5: A divide whose top entry is zero sets err, leaves the stack unchanged and does not deassert in_ready.
- R6: Any binary opcode accepted with fewer than two entries sets err and leaves the stack unchanged.
- R7: A push accepted with 16 entries sets err and leaves the stack unchanged. Depth never exceeds 16.
- R8: err stays set until reset, whatever instructions follow.
- R9: Opcodes 3'b101 to 3'b111 are ignored. They leave the stack and err unchanged.
- R10: The instructions push 8, push 2, push 5, multiply, add, push 1, push 3, push 2, multiply, add, push 4, subtract, divide take the (top, depth) pair through (8,1) (2,2) (5,3) (10,2) (18,1) (1,2) (3,3) (2,4) (6,3) (7,2) (4,3) (3,2) and end at (6,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can accept an instruction (low while dividing) |
| in_op | input | 3 | Opcode |
| in_imm | input | 8 | Signed immediate for push |
| top_value | output | 32 | Current top entry, 0 when the stack is empty |
| depth | output | 5 | Number of entries held |
| err | output | 1 | Sticky error flag |

## Verification
The checker assumes that in_op and in_imm are stable in every cycle where in_valid is high. It also assumes that nothing is counted as accepted unless in_ready is high, so every property is keyed on the handshake firing. The bench drives instruction fields only at falling edges, holds in_valid for a single cycle, and waits for in_ready to return high before it issues the next instruction. A stall therefore never overlaps a new request.

// File: rtl/postfix_stack_eval.sv
module postfix_stack_eval #(
  parameter int W = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [2:0]                 in_op,
  input  logic [7:0]                 in_imm,
  output logic [W-1:0]               top_value,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       err
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  stk [DEPTH];
  logic          busy, neg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem, quo, dvs;

  wire fire = in_valid && in_ready;
  assign in_ready = !busy;

  wire [AW-1:0] ti = AW'(depth - DW'(1));
  wire [AW-1:0] si = AW'(depth - DW'(2));
  wire [W-1:0]  b  = stk[ti];
  wire [W-1:0]  a  = stk[si];
  assign top_value = (depth == '0) ? '0 : b;

  wire is_push = in_op == 3'd0;
  wire is_arith = in_op inside {3'd1, 3'd2, 3'd3};
  wire is_div = in_op == 3'd4;
  wire few = depth < DW'(2);
  wire full = depth == DW'(DEPTH);
  wire bad = (is_push && full) || ((is_arith || is_div) && few) || (is_div && !few && b == '0);

  logic [W-1:0] alu;
  always_comb begin
    case (in_op)
      3'd1:    alu = a + b;
      3'd2:    alu = a - b;
      3'd3:    alu = a * b;
      default: alu = '0;
    endcase
  end

  wire [W:0]   rem_sh = {rem, quo[W-1]};
  wire [W:0]   diff   = rem_sh - {1'b0, dvs};
  wire         ge     = !diff[W];
  wire [W-1:0] rem_n  = ge ? diff[W-1:0] : rem_sh[W-1:0];
  wire [W-1:0] quo_n  = {quo[W-2:0], ge};
  wire [W-1:0] qres   = neg ? -quo_n : quo_n;
  wire         last   = busy && cnt == CW'(1);

  logic          wr_en;
  logic [AW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  always_comb begin
    wr_en = 1'b0;
    wr_idx = si;
    wr_data = alu;
    if (last) begin
      wr_en = 1'b1;
      wr_data = qres;
    end else if (fire && !bad && is_push) begin
      wr_en = 1'b1;
      wr_idx = AW'(depth);
      wr_data = {{(W-8){in_imm[7]}}, in_imm};
    end else if (fire && !bad && is_arith) begin
      wr_en = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stk[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      err <= 1'b0;
      busy <= 1'b0;
      cnt <= '0;
      rem <= '0;
      quo <= '0;
      dvs <= '0;
      neg <= 1'b0;
    end else if (busy) begin
      rem <= rem_n;
      quo <= quo_n;
      cnt <= cnt - CW'(1);
      if (last) begin
        busy <= 1'b0;
        depth <= depth - DW'(1);
      end
    end else if (fire) begin
      if (bad) err <= 1'b1;
      else if (is_push) depth <= depth + DW'(1);
      else if (is_arith) depth <= depth - DW'(1);
      else if (is_div) begin
        busy <= 1'b1;
        cnt <= CW'(W);
        rem <= '0;
        quo <= a[W-1] ? -a : a;
        dvs <= b[W-1] ? -b : b;
        neg <= a[W-1] ^ b[W-1];
      end
    end
  end
endmodule

// File: rtl/postfix_stack_eval_chk.sv
module postfix_stack_eval_chk #(
  parameter int W = 32,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [2:0]                 in_op,
  input logic [7:0]                 in_imm,
  input logic [W-1:0]               top_value,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic                       err
);
  localparam int DW = $clog2(DEPTH + 1);
  wire fire = in_valid && in_ready;
  wire binop = in_op inside {3'd1, 3'd2, 3'd3, 3'd4};

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));
  assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd0 && depth < DW'(DEPTH) |=>
      depth == $past(depth) + DW'(1) && top_value == {{(W-8){$past(in_imm[7])}}, $past(in_imm)});
  assert_arith_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op inside {3'd1, 3'd2, 3'd3} && depth >= DW'(2) |=> depth == $past(depth) - DW'(1));
  assert_div_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd4 && depth >= DW'(2) && top_value != '0 |=> !in_ready && $stable(depth));
  assert_div_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op == 3'd4 && depth >= DW'(2) && top_value == '0 |=> err && in_ready && $stable(depth));
  assert_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && binop && depth < DW'(2) |=> err && $stable(depth) && $stable(top_value));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_op >= 3'd5 |=> $stable(depth) && $stable(top_value) && $stable(err));
endmodule

bind postfix_stack_eval postfix_stack_eval_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_postfix_stack_eval.sv
`timescale 1ns/1ps
module tb_postfix_stack_eval;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [2:0] in_op = 0;
  logic [7:0] in_imm = 0;
  logic in_ready, err;
  logic [31:0] top_value;
  logic [4:0] depth;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  postfix_stack_eval dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_imm(in_imm), .top_value(top_value), .depth(depth), .err(err));

  localparam logic [2:0] PUSH = 0, ADD = 1, SUB = 2, MUL = 3, DIV = 4;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0; in_valid = 0;
    @(negedge clk); @(negedge clk) rst_n = 1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] imm);
    while (!in_ready) @(negedge clk);
    in_op = op; in_imm = imm; in_valid = 1;
    @(negedge clk) in_valid = 0;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic expect_state(input string req, input logic [31:0] t, input int d);
    chk({req, " top"}, top_value, t);
    chk({req, " depth"}, 32'(depth), 32'(d));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 depth", 32'(depth), 0);
    chk("R1 top", top_value, 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 ready", 32'(in_ready), 1);
  endtask

  task automatic t_push();
    do_reset();
    issue(PUSH, 8'hFF); expect_state("R2 neg", 32'hFFFF_FFFF, 1);
    issue(PUSH, 8'h7F); expect_state("R2 pos", 32'h7F, 2);
    issue(PUSH, 8'h80); expect_state("R2 min", 32'hFFFF_FF80, 3);
  endtask

  task automatic binop(input string req, input logic [2:0] op, input logic [7:0] x, input logic [7:0] y,
                       input logic [31:0] exp);
    do_reset();
    issue(PUSH, x); issue(PUSH, y); issue(op, 0);
    expect_state(req, exp, 1);
    chk({req, " err"}, 32'(err), 0);
  endtask

  task automatic t_arith();
    logic [31:0] p;
    binop("R3 add", ADD, 8'd100, 8'hF6, 32'd90);
    binop("R3 sub order", SUB, 8'd3, 8'd7, 32'hFFFF_FFFC);
    binop("R3 sub", SUB, 8'd7, 8'd3, 32'd4);
    binop("R3 mul", MUL, 8'hFD, 8'd5, 32'hFFFF_FFF1);
    do_reset();
    p = 32'd127;
    issue(PUSH, 8'd127);
    for (int i = 0; i < 4; i++) begin
      issue(PUSH, 8'd127); issue(MUL, 0);
      p = p * 32'd127;
    end
    expect_state("R3 mul wrap", p, 1);
  endtask

  task automatic divtest(input string req, input logic [7:0] x, input logic [7:0] y, input logic [31:0] exp);
    int low;
    do_reset();
    issue(PUSH, x); issue(PUSH, y);
    in_op = DIV; in_valid = 1;
    @(negedge clk) in_valid = 0;
    low = 0;
    while (!in_ready && low < 100) begin low++; @(negedge clk); end
    chk({req, " stall cycles"}, 32'(low), 32);
    expect_state(req, exp, 1);
  endtask

  task automatic t_div();
    divtest("R4 pos", 8'd7, 8'd2, 32'd3);
    divtest("R4 negnum", 8'hF9, 8'd2, 32'hFFFF_FFFD);
    divtest("R4 negden", 8'd7, 8'hFE, 32'hFFFF_FFFD);
    divtest("R4 bothneg", 8'hF8, 8'hFE, 32'd4);
    do_reset();
    issue(PUSH, 8'h80); issue(PUSH, 8'h80); issue(MUL, 0);
    issue(PUSH, 8'h80); issue(MUL, 0);
    issue(PUSH, 8'h80); issue(MUL, 0);
    issue(PUSH, 8'hF8); issue(MUL, 0);
    expect_state("R4 build min", 32'h8000_0000, 1);
    issue(PUSH, 8'hFF); issue(DIV, 0);
    expect_state("R4 min by -1", 32'h8000_0000, 1);
  endtask

  task automatic t_divzero();
    do_reset();
    issue(PUSH, 8'd5); issue(PUSH, 8'd0);
    in_op = DIV; in_valid = 1;
    @(negedge clk) in_valid = 0;
    chk("R5 ready", 32'(in_ready), 1);
    chk("R5 err", 32'(err), 1);
    expect_state("R5", 0, 2);
  endtask

  task automatic t_underflow();
    do_reset();
    issue(ADD, 0);
    chk("R6 empty err", 32'(err), 1);
    expect_state("R6 empty", 0, 0);
    do_reset();
    issue(PUSH, 8'd1); issue(DIV, 0);
    chk("R6 one err", 32'(err), 1);
    expect_state("R6 one", 1, 1);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 16; i++) issue(PUSH, 8'(i + 1));
    expect_state("R7 filled", 16, 16);
    chk("R7 no err", 32'(err), 0);
    issue(PUSH, 8'd99);
    chk("R7 err", 32'(err), 1);
    expect_state("R7 over", 16, 16);
    issue(SUB, 0);
    expect_state("R7 below intact", 32'hFFFF_FFFF, 15);
  endtask

  task automatic t_sticky();
    do_reset();
    issue(MUL, 0);
    issue(PUSH, 8'd2); issue(PUSH, 8'd3); issue(ADD, 0);
    chk("R8 err held", 32'(err), 1);
    expect_state("R8 still works", 5, 1);
    do_reset();
    chk("R8 cleared by reset", 32'(err), 0);
  endtask

  task automatic t_ignore();
    do_reset();
    issue(PUSH, 8'd9);
    for (int op = 5; op < 8; op++) begin
      issue(3'(op), 8'd1);
      expect_state("R9", 9, 1);
      chk("R9 err", 32'(err), 0);
    end
  endtask

  task automatic t_sequence();
    logic [2:0] ops [13] = '{PUSH, PUSH, PUSH, MUL, ADD, PUSH, PUSH, PUSH, MUL, ADD, PUSH, SUB, DIV};
    logic [7:0] imms [13] = '{8, 2, 5, 0, 0, 1, 3, 2, 0, 0, 4, 0, 0};
    int tops [13] = '{8, 2, 5, 10, 18, 1, 3, 2, 6, 7, 4, 3, 6};
    int deps [13] = '{1, 2, 3, 2, 1, 2, 3, 4, 3, 2, 3, 2, 1};
    do_reset();
    for (int i = 0; i < 13; i++) begin
      issue(ops[i], imms[i]);
      expect_state("R10", 32'(tops[i]), deps[i]);
    end
    chk("R10 err", 32'(err), 0);
  endtask

  initial begin
    t_reset(); t_push(); t_arith(); t_div(); t_divzero();
    t_underflow(); t_full(); t_sticky(); t_ignore(); t_sequence();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule